// File: doc/BRIEF.md
# Slot-Addressed Bus Slave Decoder

This block is the address-recognition front end of a plug-in slave card on a 32-bit backplane. The card learns which slot it sits in from five active-low slot pins, or from a 5-bit jumper value when jumpers are enabled. That slot number becomes the top five bits of a fixed 128 MB address window. Software cannot move this window. The number is captured once, right after reset, and held until the next reset.

Each qualified bus cycle presents a 32-bit address, a 6-bit address-modifier code and a direction bit. One clock later the block reports whether the card was selected. Selected reads at the four lowest byte offsets of the window are answered from a small parameter-defined identification ROM: one card-type byte and three user bytes. Selected accesses at offset 4 and above raise a strobe for the card's local registers. A select indicator output is held on for a minimum visible time after the most recent selection, so a person watching the front panel can see it.

Top module: `geo_slave_decode`

## Requirements
- R1: The slot number is the bitwise inverse of `slot_pin_n` (a grounded pin reads 1). A cycle selects the card only when `bus_addr[31:27]` equals the captured slot number.
- R2: `slot_par_n` has no effect on selection or on any output.
- R3: While `jmp_en` is 1 at capture time, `jmp_slot` replaces the pin-derived slot number.
- R4: Only the modifier codes 0x08, 0x09, 0x0A and 0x0B are accepted. Any other 6-bit code never selects.
- R5: The slot number is captured on the first clock after the internally synchronized reset releases. Later changes of the pins or jumpers do not move the window.
- R6: A captured slot number of 0 disables all selection.
- R7: `sel` is 1 in the cycle after a cycle with `bus_valid`=1 that matches slot and modifier. It is 0 in every other cycle.
- R8: A selected read (`bus_write`=0) at offset `bus_addr[26:0]` 0..3 sets `rom_vld` together with `sel`. `rom_data` then carries `TYPE_CODE` for offset 0 and `USER_B1`, `USER_B2`, `USER_B3` for offsets 1, 2, 3. `rom_data` is 0 whenever `rom_vld` is 0.
- R9: A selected write at offsets 0..3 raises `sel` only. It raises neither `rom_vld` nor `lreg_req`, and later ROM reads return unchanged bytes.
- R10: A selected access at offset 4 or above raises `lreg_req` with `sel` and never `rom_vld`.
- R11: `led_on` is 1 from the cycle `sel` rises until exactly HOLD_CYC = CLK_HZ/1000*HOLD_MS cycles after the last selecting clock edge. Each new selection restarts the hold.
- R12: While reset is active, `sel`, `rom_vld`, `lreg_req`, `led_on` and `rom_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_pin_n | input | 5 | Active-low slot pins |
| slot_par_n | input | 1 | Slot parity pin, ignored |
| jmp_en | input | 1 | Jumper override enable |
| jmp_slot | input | 5 | Jumper slot number |
| bus_valid | input | 1 | Qualifies the address phase of a cycle |
| bus_addr | input | 32 | Cycle address |
| bus_am | input | 6 | Cycle address-modifier code |
| bus_write | input | 1 | 1 for write, 0 for read |
| sel | output | 1 | Card selected (registered) |
| rom_vld | output | 1 | ROM read answered |
| rom_data | output | 8 | ROM byte |
| lreg_req | output | 1 | Local register access strobe |
| led_on | output | 1 | Stretched select indicator |

## Verification
The hardest situation to reach is a change of the slot sources after capture. It only shows up if the bench moves the pins or the jumpers mid-run and then hits both the old window and the new one. The stimulus does exactly that, and it also repeats reset with jumpers on, with a slot of 0, and with a parity pin that disagrees. Random cycles aim half their addresses at the card's own window and half their modifiers at the accepted set, so that selections are frequent. Short idle gaps let the indicator hold both expire and restart.

// File: rtl/geo_dec_pkg.sv
package geo_dec_pkg;
  localparam int SLOT_W = 5;
  localparam int ADDR_W = 32;
  localparam int AM_W   = 6;
  localparam int OFF_W  = ADDR_W - SLOT_W;
  localparam int ROM_N  = 4;
  localparam int ROM_AW = $clog2(ROM_N);

  // accepted codes 0x08..0x0B share the upper pattern 0010
  function automatic logic am_accepted(input logic [AM_W-1:0] am);
    return am[AM_W-1:2] == 4'b0010;
  endfunction
endpackage

// File: rtl/geo_slot_latch.sv
module geo_slot_latch
  import geo_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] pin_n,
  input  logic              jmp_en,
  input  logic [SLOT_W-1:0] jmp_slot,
  output logic [SLOT_W-1:0] slot,
  output logic              slot_ok
);
  logic              done_q, done_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    done_d = 1'b1;
    slot_d = slot_q;
    if (!done_q) slot_d = jmp_en ? jmp_slot : ~pin_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      slot_q <= '0;
    end else begin
      done_q <= done_d;
      slot_q <= slot_d;
    end
  end

  assign slot    = slot_q;
  assign slot_ok = done_q && (slot_q != '0);

  // R5
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_q) |-> $stable(slot_q));
endmodule

// File: rtl/geo_addr_match.sv
module geo_addr_match
  import geo_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic              slot_ok,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [AM_W-1:0]   bus_am,
  input  logic              bus_write,
  output logic              hit,
  output logic              sel_q,
  output logic              rom_q,
  output logic              lreg_q,
  output logic [ROM_AW-1:0] off_q
);
  logic [OFF_W-1:0] offs;
  logic             low_win;
  logic             rom_d, lreg_d;

  always_comb begin
    offs    = bus_addr[OFF_W-1:0];
    low_win = (offs[OFF_W-1:ROM_AW] == '0);
    hit     = bus_valid && slot_ok && am_accepted(bus_am) &&
              (bus_addr[ADDR_W-1:OFF_W] == slot);
    rom_d   = hit && low_win && !bus_write;
    lreg_d  = hit && !low_win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      rom_q  <= 1'b0;
      lreg_q <= 1'b0;
      off_q  <= '0;
    end else begin
      sel_q  <= hit;
      rom_q  <= rom_d;
      lreg_q <= lreg_d;
      if (hit) off_q <= offs[ROM_AW-1:0];
    end
  end

  // R4
  am_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |-> ($past(bus_am) >= 6'h08 && $past(bus_am) <= 6'h0B));
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_q, lreg_q}) && ((rom_q || lreg_q) -> sel_q));
endmodule

// File: rtl/geo_cfg_rom.sv
module geo_cfg_rom
  import geo_dec_pkg::*;
#(
  parameter logic [7:0] TYPE_CODE = 8'h01,
  parameter logic [7:0] USER_B1   = 8'h00,
  parameter logic [7:0] USER_B2   = 8'h00,
  parameter logic [7:0] USER_B3   = 8'h00
) (
  input  logic              rd_en,
  input  logic [ROM_AW-1:0] off,
  output logic [7:0]        data
);
  logic [ROM_N-1:0][7:0] bytes;

  assign bytes = {USER_B3, USER_B2, USER_B1, TYPE_CODE};

  always_comb begin
    data = '0;
    if (rd_en) data = bytes[off];
  end
endmodule

// File: rtl/geo_led_stretch.sv
module geo_led_stretch #(
  parameter int HOLD_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic led_on
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (trig)               cnt_d = RELOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign led_on = (cnt_q != '0);

  // R11
  led_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) != '0 && !$past(trig)) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/geo_slave_decode.sv
module geo_slave_decode
  import geo_dec_pkg::*;
#(
  parameter logic [7:0] TYPE_CODE = 8'h01,
  parameter logic [7:0] USER_B1   = 8'h00,
  parameter logic [7:0] USER_B2   = 8'h00,
  parameter logic [7:0] USER_B3   = 8'h00,
  parameter int         CLK_HZ    = 250_000_000,
  parameter int         HOLD_MS   = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  slot_pin_n,
  input  logic        slot_par_n,
  input  logic        jmp_en,
  input  logic [4:0]  jmp_slot,
  input  logic        bus_valid,
  input  logic [31:0] bus_addr,
  input  logic [5:0]  bus_am,
  input  logic        bus_write,
  output logic        sel,
  output logic        rom_vld,
  output logic [7:0]  rom_data,
  output logic        lreg_req,
  output logic        led_on
);
  localparam int HOLD_CYC = CLK_HZ / 1000 * HOLD_MS;

  logic              rst_m, rst_s;
  logic [SLOT_W-1:0] slot;
  logic              slot_ok, hit;
  logic [ROM_AW-1:0] off_q;
  logic              par_unused;

  assign par_unused = slot_par_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  geo_slot_latch u_slot (
    .clk(clk), .rst_n(rst_s), .pin_n(slot_pin_n), .jmp_en(jmp_en),
    .jmp_slot(jmp_slot), .slot(slot), .slot_ok(slot_ok)
  );

  geo_addr_match u_match (
    .clk(clk), .rst_n(rst_s), .slot(slot), .slot_ok(slot_ok),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_am(bus_am),
    .bus_write(bus_write), .hit(hit), .sel_q(sel), .rom_q(rom_vld),
    .lreg_q(lreg_req), .off_q(off_q)
  );

  geo_cfg_rom #(
    .TYPE_CODE(TYPE_CODE), .USER_B1(USER_B1),
    .USER_B2(USER_B2), .USER_B3(USER_B3)
  ) u_rom (
    .rd_en(rom_vld), .off(off_q), .data(rom_data)
  );

  geo_led_stretch #(.HOLD_CYC(HOLD_CYC)) u_led (
    .clk(clk), .rst_n(rst_s), .trig(hit), .led_on(led_on)
  );

  // R11
  sel_led_chk: assert property (@(posedge clk) disable iff (!rst_s)
    sel |-> led_on);
  // R7
  sel_cause_chk: assert property (@(posedge clk) disable iff (!rst_s)
    sel |-> $past(bus_valid));
endmodule

// File: tb/geo_slave_decode_bench.sv
module geo_slave_decode_bench;
  localparam logic [7:0] T_TYPE = 8'h03;
  localparam logic [7:0] T_U1 = 8'hA1, T_U2 = 8'hB2, T_U3 = 8'hC3;
  localparam int HOLD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] slot_pin_n = 5'h1F, jmp_slot = 5'h00;
  logic slot_par_n = 1'b1, jmp_en = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [5:0] bus_am = '0;
  logic sel, rom_vld, lreg_req, led_on;
  logic [7:0] rom_data;

  int total = 0, bad = 0, led_cnt = 0;
  logic [4:0] tb_slot = '0;
  logic e_sel = 0, e_rom = 0, e_lreg = 0;
  logic [7:0] e_data = 0;
  bit done = 0;

  always #2 clk = ~clk;

  geo_slave_decode #(
    .TYPE_CODE(T_TYPE), .USER_B1(T_U1), .USER_B2(T_U2), .USER_B3(T_U3),
    .CLK_HZ(1000), .HOLD_MS(HOLD)
  ) u_geo_slave_decode (
    .clk(clk), .rst_n(rst_n), .slot_pin_n(slot_pin_n), .slot_par_n(slot_par_n),
    .jmp_en(jmp_en), .jmp_slot(jmp_slot), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_am(bus_am), .bus_write(bus_write),
    .sel(sel), .rom_vld(rom_vld), .rom_data(rom_data),
    .lreg_req(lreg_req), .led_on(led_on)
  );

  function automatic logic [7:0] rom_byte(input logic [1:0] o);
    case (o)
      2'd0: return T_TYPE;
      2'd1: return T_U1;
      2'd2: return T_U2;
      default: return T_U3;
    endcase
  endfunction

  task automatic check(input string tag);
    logic [11:0] got, exp;
    got = {sel, rom_vld, lreg_req, led_on, rom_data};
    exp = {e_sel, e_rom, e_lreg, led_cnt != 0, e_data};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got sel/rom/lreg/led/data=%b actual, expected %b", tag, got, exp);
    end
  endtask

  // drive one cycle, model the registered result, check after the edge
  task automatic cyc(input logic v, input logic [31:0] a, input logic [5:0] m,
                     input logic w, input string tag);
    logic hit, low;
    bus_valid = v; bus_addr = a; bus_am = m; bus_write = w;
    low = (a[26:2] == '0);
    hit = v && (tb_slot != 0) && (a[31:27] == tb_slot) && (m >= 6'h08 && m <= 6'h0B);
    @(posedge clk);
    e_sel = hit; e_rom = hit && low && !w; e_lreg = hit && !low;
    e_data = e_rom ? rom_byte(a[1:0]) : 8'h00;
    if (hit) led_cnt = HOLD; else if (led_cnt > 0) led_cnt--;
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset(input logic [4:0] pins_n, input logic par,
                          input logic je, input logic [4:0] js);
    @(negedge clk);
    rst_n = 0; bus_valid = 0;
    slot_pin_n = pins_n; slot_par_n = par; jmp_en = je; jmp_slot = js;
    repeat (2) @(negedge clk);
    e_sel = 0; e_rom = 0; e_lreg = 0; e_data = 0; led_cnt = 0;
    check("R12 reset");
    tb_slot = je ? js : ~pins_n;
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] at(input logic [4:0] s, input logic [26:0] o);
    return {s, o};
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    // slot 5 via pins
    do_reset(~5'd5, 1'b0, 1'b0, 5'd0);
    for (int i = 0; i < 4; i++) cyc(1, at(5, 27'(i)), 6'h09, 0, "R8 rom read");
    cyc(1, at(5, 0), 6'h0A, 1, "R9 rom write");
    cyc(1, at(5, 0), 6'h08, 0, "R9 rom after write");
    cyc(1, at(5, 4), 6'h0B, 0, "R10 lreg low");
    cyc(1, at(5, 27'h7FFFFFF), 6'h09, 1, "R10 lreg top");
    cyc(1, at(5, 1), 6'h0C, 0, "R4 am 0C");
    cyc(1, at(5, 1), 6'h07, 0, "R4 am 07");
    cyc(1, at(5, 1), 6'h39, 0, "R4 am 39");
    cyc(1, at(6, 1), 6'h09, 0, "R1 other slot");
    cyc(0, at(5, 1), 6'h09, 0, "R7 not valid");
    repeat (HOLD + 2) cyc(0, 0, 0, 0, "R11 hold expiry");
    cyc(1, at(5, 8), 6'h09, 0, "R11 retrigger");
    repeat (5) cyc(0, 0, 0, 0, "R11 partial");
    cyc(1, at(5, 2), 6'h09, 0, "R11 reload");
    repeat (HOLD + 1) cyc(0, 0, 0, 0, "R11 hold after reload");
    // move pins after capture
    slot_pin_n = ~5'd9; jmp_en = 1; jmp_slot = 5'd12;
    cyc(1, at(5, 3), 6'h09, 0, "R5 old window kept");
    cyc(1, at(9, 3), 6'h09, 0, "R5 new pins ignored");
    cyc(1, at(12, 3), 6'h09, 0, "R5 jumper ignored");
    slot_par_n = ~slot_par_n;
    cyc(1, at(5, 0), 6'h08, 0, "R2 parity toggle");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] s; logic [26:0] o; logic [5:0] m;
      s = ($urandom % 2) ? tb_slot : 5'($urandom);
      o = ($urandom % 2) ? 27'($urandom % 8) : 27'($urandom);
      m = ($urandom % 2) ? 6'(8 + $urandom % 4) : 6'($urandom);
      if (i % 200 == 0) slot_par_n = 1'($urandom);
      cyc(($urandom % 4) != 0, at(s, o), m, 1'($urandom), "R1 R7 random");
    end
    // slot 21 with a parity pin that disagrees
    do_reset(~5'd21, 1'b1, 1'b0, 5'd0);
    cyc(1, at(21, 0), 6'h0B, 0, "R2 bad parity");
    cyc(1, at(21, 3), 6'h0A, 0, "R1 slot 21");
    // jumper override
    do_reset(~5'd3, 1'b0, 1'b1, 5'd30);
    cyc(1, at(30, 1), 6'h09, 0, "R3 jumper slot");
    cyc(1, at(3, 1), 6'h09, 0, "R3 pins overridden");
    for (int i = 0; i < 500; i++)
      cyc(1'($urandom), at(($urandom % 2) ? 5'd30 : 5'($urandom), 27'($urandom % 16)),
          6'(6 + $urandom % 8), 1'($urandom), "R3 random");
    // slot zero
    do_reset(5'h1F, 1'b0, 1'b0, 5'd0);
    for (int i = 0; i < 200; i++)
      cyc(1, at(0, 27'($urandom % 16)), 6'(8 + $urandom % 4), 1'($urandom), "R6 slot zero");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual hung, expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule